// File: doc/BRIEF.md
# Dual-Clock FIFO with Threshold and Error Flags

This block moves data words from a producer running on one clock to a consumer running on an unrelated clock. Each side keeps its own binary position counter and publishes a reflected-binary (Gray) copy of it. The other side receives that copy through a short chain of flip-flops clocked by its own clock. Each side then compares its own pointer with the one it received. The write side works out whether the store is full. The read side works out whether it is empty. Each side also works out a fill level from the two pointers.

Besides full and empty, each side compares its fill level with a threshold that software may change at any time. This gives an early-warning flag on each side. Each side also latches an error flag when the user tries an access the state forbids: a write into a full store, or a read from an empty one. The forbidden access itself is dropped. The error flag stays set until that side's own reset.

Both pointers carry one bit more than the storage address. This extra wrap bit is what tells full apart from empty. The storage depth is two to the power of the address width.

Top module: `xdom_fifo`

## Requirements
- R1: While both resets are low and right after they are released, `rd_empty`=1, `wr_full`=0, `wr_ovf`=0, `rd_unf`=0, `rd_data`=0, and `rd_aempty`=1. `wr_afull`=0 whenever `wr_afull_lvl` is nonzero.
- R2: Words leave through `rd_data` in the order in which they were accepted. `rd_data` is updated at the read-clock edge that sees `rd_en`=1 with `rd_empty`=0.
- R3: With no reads, `wr_full` is 0 after DEPTH-1 accepted writes. It is 1 just after the write-clock edge that accepts write number DEPTH.
- R4: A write presented while `wr_full`=1 is not stored, and the write pointer holds. Draining the store afterwards returns exactly the DEPTH earlier words, followed by `rd_empty`=1.
- R5: `wr_ovf` becomes 1 after a write-clock edge where `wr_en`=1 and `wr_full`=1. It then stays 1 until `wr_rst_n` goes low.
- R6: `rd_unf` becomes 1 after a read-clock edge where `rd_en`=1 and `rd_empty`=1. It then stays 1 until `rd_rst_n` goes low. Such a read leaves `rd_data` unchanged.
- R7: `rd_empty` is 1 just after the read edge that takes the last stored word. After a write, `rd_empty` falls within SYNC_N+1 read-clock edges.
- R8: `wr_afull` is 1 exactly when the write-side level is greater than or equal to `wr_afull_lvl`. The write-side level is the write count minus the synchronized read count. A new `wr_afull_lvl` takes effect at once.
- R9: `rd_aempty` is 1 exactly when the read-side level is less than or equal to `rd_aempty_lvl`. The read-side level is the synchronized write count minus the read count.
- R10: When writes and reads run together on both clocks, with the writer held back by `wr_full`, every word arrives intact and in order. Neither error flag is raised. Each published Gray pointer changes in at most one bit per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_afull_lvl | input | ADDR_W+1 | Almost-full threshold |
| wr_full | output | 1 | No free location |
| wr_afull | output | 1 | Level at or above threshold |
| wr_ovf | output | 1 | Sticky: write attempted while full |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side reset, active low |
| rd_en | input | 1 | Read request |
| rd_aempty_lvl | input | ADDR_W+1 | Almost-empty threshold |
| rd_data | output | DATA_W | Registered output word |
| rd_empty | output | 1 | No stored word |
| rd_aempty | output | 1 | Level at or below threshold |
| rd_unf | output | 1 | Sticky: read attempted while empty |

## Verification
The two actions that can coincide are a write that the writer is about to present and a read that frees a slot. Both touch the same full/empty boundary from opposite clocks. The streaming scenario provokes this. A writer on the 20 ns clock pushes at full rate, stalling only when `wr_full` is set. At the same time a reader on a 34 ns clock pulls words as soon as `rd_empty` clears, so the store sits near full while both pointers move. The run is judged by comparing each word received with the bench's own sequence. It also checks that both error flags stay clear and that the store ends empty.

// File: rtl/xdom_fifo_pkg.sv
package xdom_fifo_pkg;

   // binary to reflected-binary code
   function automatic logic [31:0] bin2gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   // reflected-binary back to binary by prefix XOR
   function automatic logic [31:0] gray2bin(input logic [31:0] g);
      logic [31:0] b;
      b = g;
      for (int s = 1; s < 32; s = s * 2) b = b ^ (b >> s);
      return b;
   endfunction

endpackage

// File: rtl/xdom_sync.sv
module xdom_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= '0;
         else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/xdom_store.sv
module xdom_store #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/xdom_wr_ctrl.sv
module xdom_wr_ctrl
   import xdom_fifo_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int SYNC_N = 2,
   localparam int PTR_W = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [PTR_W-1:0]  lvl,
   input  logic [PTR_W-1:0]  rgray_async,
   output logic [PTR_W-1:0]  wgray,
   output logic [ADDR_W-1:0] waddr,
   output logic              push,
   output logic              full,
   output logic              afull,
   output logic              ovf
);
   localparam logic [PTR_W-1:0] WRAP_MASK = PTR_W'(3 << (PTR_W - 2));

   logic [PTR_W-1:0] rgray_s, rbin_s, wbin, wbin_nx, level;

   xdom_sync #(.W(PTR_W), .STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rgray_async), .q(rgray_s));

   assign full    = ((wgray ^ rgray_s) == WRAP_MASK);
   assign push    = en && !full;
   assign wbin_nx = wbin + PTR_W'(push);
   assign waddr   = wbin[ADDR_W-1:0];
   assign rbin_s  = PTR_W'(gray2bin(32'(rgray_s)));
   assign level   = wbin - rbin_s;
   assign afull   = (level >= lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
         ovf   <= 1'b0;
      end else begin
         wbin  <= wbin_nx;
         wgray <= PTR_W'(bin2gray(32'(wbin_nx)));
         ovf   <= ovf | (en & full);
      end
   end

   // R5: error flag is sticky until reset
   assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   // R5: a write into a full store raises the flag
   assert_ovf_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && full) |=> ovf);
   // R4: rejected write leaves the published pointer alone
   assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && full) |=> $stable(wgray));
   // R10: one bit per step on the crossing pointer
   assert_wgray_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/xdom_rd_ctrl.sv
module xdom_rd_ctrl
   import xdom_fifo_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3,
   parameter int SYNC_N = 2,
   localparam int PTR_W = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [PTR_W-1:0]  lvl,
   input  logic [PTR_W-1:0]  wgray_async,
   input  logic [DATA_W-1:0] mem_q,
   output logic [PTR_W-1:0]  rgray,
   output logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] data,
   output logic              empty,
   output logic              aempty,
   output logic              unf
);
   logic [PTR_W-1:0] wgray_s, wbin_s, rbin, rbin_nx, level;
   logic             pop;

   xdom_sync #(.W(PTR_W), .STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(wgray_async), .q(wgray_s));

   assign empty   = (rgray == wgray_s);
   assign pop     = en && !empty;
   assign rbin_nx = rbin + PTR_W'(pop);
   assign raddr   = rbin[ADDR_W-1:0];
   assign wbin_s  = PTR_W'(gray2bin(32'(wgray_s)));
   assign level   = wbin_s - rbin;
   assign aempty  = (level <= lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin  <= '0;
         rgray <= '0;
         data  <= '0;
         unf   <= 1'b0;
      end else begin
         rbin  <= rbin_nx;
         rgray <= PTR_W'(bin2gray(32'(rbin_nx)));
         unf   <= unf | (en & empty);
         if (pop) data <= mem_q;
      end
   end

   // R6: sticky underflow
   assert_unf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      unf |=> unf);
   // R6: read from empty leaves the output word unchanged
   assert_empty_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && empty) |=> ($stable(data) && $stable(rgray)));
   // R10: one bit per step on the crossing pointer
   assert_rgray_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/xdom_fifo.sv
module xdom_fifo #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3,
   parameter int SYNC_N = 2,
   localparam int PTR_W = ADDR_W + 1
) (
   input  logic              wr_clk,
   input  logic              wr_rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  wr_afull_lvl,
   output logic              wr_full,
   output logic              wr_afull,
   output logic              wr_ovf,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   input  logic              rd_en,
   input  logic [PTR_W-1:0]  rd_aempty_lvl,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_empty,
   output logic              rd_aempty,
   output logic              rd_unf
);
   if (DATA_W < 1) begin : g_bad_data
      $error("xdom_fifo: DATA_W must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("xdom_fifo: ADDR_W must lie in 1..16");
   end
   if (SYNC_N < 2) begin : g_bad_sync
      $error("xdom_fifo: SYNC_N must be at least 2");
   end

   logic [PTR_W-1:0]  wgray, rgray;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [DATA_W-1:0] mem_q;
   logic              push;

   xdom_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
      .wclk(wr_clk), .we(push), .waddr(waddr), .wdata(wr_data),
      .raddr(raddr), .rdata(mem_q));

   xdom_wr_ctrl #(.ADDR_W(ADDR_W), .SYNC_N(SYNC_N)) u_wr (
      .clk(wr_clk), .rst_n(wr_rst_n), .en(wr_en), .lvl(wr_afull_lvl),
      .rgray_async(rgray), .wgray(wgray), .waddr(waddr), .push(push),
      .full(wr_full), .afull(wr_afull), .ovf(wr_ovf));

   xdom_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_N(SYNC_N)) u_rd (
      .clk(rd_clk), .rst_n(rd_rst_n), .en(rd_en), .lvl(rd_aempty_lvl),
      .wgray_async(wgray), .mem_q(mem_q), .rgray(rgray), .raddr(raddr),
      .data(rd_data), .empty(rd_empty), .aempty(rd_aempty), .unf(rd_unf));
endmodule

// File: tb/sim_xdom_fifo.sv
`timescale 1ns/1ps
module sim_xdom_fifo;
   localparam int DW = 8;
   localparam int AW = 3;
   localparam int PW = AW + 1;
   localparam int DEPTH = 1 << AW;

   logic          wr_clk = 0, rd_clk = 0;
   logic          wr_rst_n = 0, rd_rst_n = 0;
   logic          wr_en = 0, rd_en = 0;
   logic [DW-1:0] wr_data = '0;
   logic [PW-1:0] wr_afull_lvl = 4'd6, rd_aempty_lvl = 4'd2;
   logic          wr_full, wr_afull, wr_ovf;
   logic [DW-1:0] rd_data;
   logic          rd_empty, rd_aempty, rd_unf;

   int n_chk = 0, n_bad = 0;

   always #10 wr_clk = ~wr_clk;
   always #17 rd_clk = ~rd_clk;

   xdom_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_N(2)) u0 (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_afull_lvl(wr_afull_lvl), .wr_full(wr_full), .wr_afull(wr_afull),
      .wr_ovf(wr_ovf), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
      .rd_aempty_lvl(rd_aempty_lvl), .rd_data(rd_data), .rd_empty(rd_empty),
      .rd_aempty(rd_aempty), .rd_unf(rd_unf));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push1(input logic [DW-1:0] d);
      @(negedge wr_clk); wr_en = 1; wr_data = d;
      @(negedge wr_clk); wr_en = 0;
   endtask

   task automatic pop1(output logic [DW-1:0] d);
      @(negedge rd_clk); rd_en = 1;
      @(negedge rd_clk); rd_en = 0; d = rd_data;
   endtask

   task automatic do_reset();
      wr_en = 0; rd_en = 0;
      wr_rst_n = 0; rd_rst_n = 0;
      repeat (3) @(negedge rd_clk);
      @(negedge wr_clk); wr_rst_n = 1;
      @(negedge rd_clk); rd_rst_n = 1;
      repeat (2) @(negedge wr_clk);
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge rd_clk);
      chk("R1 empty", rd_empty, 1);
      chk("R1 aempty", rd_aempty, 1);
      chk("R1 unf", rd_unf, 0);
      chk("R1 data", rd_data, 0);
      @(negedge wr_clk);
      chk("R1 full", wr_full, 0);
      chk("R1 afull", wr_afull, 0);
      chk("R1 ovf", wr_ovf, 0);
   endtask

   task automatic t_fill();
      for (int i = 0; i < DEPTH; i++) begin
         push1(DW'(8'hA0 + i));
         if (i == 4) chk("R8 afull below lvl", wr_afull, 0);
         if (i == 5) chk("R8 afull at lvl", wr_afull, 1);
         if (i == DEPTH - 2) chk("R3 not full at DEPTH-1", wr_full, 0);
      end
      chk("R3 full at DEPTH", wr_full, 1);
      chk("R5 no ovf yet", wr_ovf, 0);
      push1(8'hEE);
      chk("R5 ovf raised", wr_ovf, 1);
      chk("R4 still full", wr_full, 1);
      @(negedge wr_clk); wr_afull_lvl = 4'd9;
      @(negedge wr_clk);
      chk("R8 runtime lvl above level", wr_afull, 0);
      wr_afull_lvl = 4'd8;
      @(negedge wr_clk);
      chk("R8 runtime lvl equal level", wr_afull, 1);
      repeat (4) @(negedge rd_clk);
      chk("R7 empty falls after sync", rd_empty, 0);
      chk("R9 aempty clear at level 8", rd_aempty, 0);
   endtask

   task automatic t_drain();
      logic [DW-1:0] d;
      for (int i = 0; i < DEPTH; i++) begin
         pop1(d);
         chk("R2 order", d, DW'(8'hA0 + i));
         if (i == 4) chk("R9 aempty above lvl", rd_aempty, 0);
         if (i == 5) chk("R9 aempty at lvl", rd_aempty, 1);
         if (i == DEPTH - 2) chk("R7 not empty before last", rd_empty, 0);
      end
      chk("R4 empty after DEPTH words", rd_empty, 1);
      chk("R6 no unf yet", rd_unf, 0);
      pop1(d);
      chk("R6 unf raised", rd_unf, 1);
      chk("R6 data held", d, 8'hA7);
      repeat (4) @(negedge wr_clk);
      chk("R3 full clears after reads", wr_full, 0);
      chk("R5 ovf sticky", wr_ovf, 1);
      repeat (3) @(negedge rd_clk);
      chk("R6 unf sticky", rd_unf, 1);
   endtask

   task automatic t_clear();
      do_reset();
      @(negedge wr_clk);
      chk("R5 ovf cleared by reset", wr_ovf, 0);
      @(negedge rd_clk);
      chk("R6 unf cleared by reset", rd_unf, 0);
   endtask

   task automatic t_stream();
      localparam int N = 40;
      int errs = 0;
      fork
         begin
            for (int i = 0; i < N; i++) begin
               @(negedge wr_clk);
               while (wr_full) begin wr_en = 0; @(negedge wr_clk); end
               wr_en = 1; wr_data = DW'(i * 7 + 3);
            end
            @(negedge wr_clk); wr_en = 0;
         end
         begin
            for (int i = 0; i < N; i++) begin
               @(negedge rd_clk);
               while (rd_empty) @(negedge rd_clk);
               rd_en = 1;
               @(negedge rd_clk); rd_en = 0;
               if (rd_data !== DW'(i * 7 + 3)) begin
                  errs++;
                  chk("R10 stream word", rd_data, DW'(i * 7 + 3));
               end
            end
         end
      join
      chk("R10 stream mismatches", errs, 0);
      chk("R10 no ovf", wr_ovf, 0);
      chk("R10 no unf", rd_unf, 0);
      repeat (4) @(negedge rd_clk);
      chk("R10 ends empty", rd_empty, 1);
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_fill();
      t_drain();
      t_clear();
      t_stream();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule